// File: doc/BRIEF.md
# Edge Capture and Pulse Measurement Unit

This unit is the capture half of one timer channel. It watches an external pin, brings it into the clock domain through two flops, and finds rising and falling transitions on the synchronised level. On a selected transition it copies a free-running counter value, supplied from outside, into a timestamp register. Rising and falling transitions each have their own timestamp register. A second path measures the pin: it finds the rise-to-rise period and the time the pin stays high in each cycle.

A 3-bit mode input chooses what is recorded: 0 off, 1 rising only, 2 falling only, 3 both directions, 4 width measurement. Codes 5 to 7 behave as off. Every recorded timestamp raises a one-cycle capture event for interrupt logic. Every synchronised transition raises a one-cycle toggle event that a DMA request selector can use, whatever the mode.

The measurement path is a four-state machine:
- MS_IDLE: width mode not selected.
- MS_ARM: waiting for the first rise.
- MS_HIGH: pin high, rise stamp held.
- MS_LOW: pin low, high time held.

Its transitions are:
- IDLE→ARM on width-mode entry. This clears both results.
- ARM→HIGH on a rise.
- HIGH→LOW on a fall.
- LOW→HIGH on a rise. This is the completing rise, and it publishes both results.
- Any state→IDLE when the mode leaves 4.

Top module: `icap_unit`

## Requirements
- R1: After reset, all four result registers read 0 and both event outputs are low.
- R2: In mode 0 (and codes 5–7) no edge changes any result register, and the capture event stays low.
- R3: In mode 1 a rising pin edge loads the counter into the rise register, and a falling edge leaves the fall register unchanged.
- R4: In mode 2 a falling pin edge loads the counter into the fall register, and a rising edge leaves the rise register unchanged.
- R5: In mode 3 both directions load their own registers.
- R6: In mode 4 the period register receives the counter difference (modulo 2^W) between two successive rising edges.
- R7: In mode 4 the high register receives the difference between a rise and the next fall, and it changes only at the rise that completes the cycle, together with the period register.
- R8: On entry into mode 4 both measurement registers become 0, and they stay 0 until the first complete rise-fall-rise cycle.
- R9: Each timestamp load raises the capture event for exactly one cycle, visible in the same cycle as the new register value.
- R10: Each synchronised pin edge of either direction raises the toggle event for one cycle, in every mode.
- R11: The value captured is the counter present at the second clock edge after the edge that first samples the new pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | W | Free-running counter value |
| pin_i | input | 1 | Raw asynchronous capture pin |
| mode_i | input | 3 | Capture mode, 0..4 |
| rise_cap_o | output | W | Counter at last recorded rising edge |
| fall_cap_o | output | W | Counter at last recorded falling edge |
| period_o | output | W | Measured rise-to-rise period |
| high_o | output | W | Measured high time |
| cap_evt_o | output | 1 | One-cycle pulse per capture |
| toggle_evt_o | output | 1 | One-cycle pulse per pin edge |

## Verification
The rise that closes a measurement cycle causes four things in one clock cycle:
- The rise timestamp loads.
- The period register updates.
- The high register updates.
- The capture event fires.

The bench provokes this in width mode with a rise, a fall and a second rise, each carrying a distinct counter value. After the closing rise it checks that all three registers hold their new values together and that the capture count grew by exactly one. A counter wrap between the two rises is also exercised. It confirms that the period and high-time differences come out modulo 2^W.

// File: rtl/icap_pkg.sv
package icap_pkg;
    typedef enum logic [2:0] {
        CM_OFF   = 3'd0,
        CM_RISE  = 3'd1,
        CM_FALL  = 3'd2,
        CM_BOTH  = 3'd3,
        CM_WIDTH = 3'd4
    } cap_mode_e;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_ARM,
        MS_HIGH,
        MS_LOW
    } meas_st_e;
endpackage

// File: rtl/icap_edge.sv
module icap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int SYNC_LEN = 2;

    logic [SYNC_LEN-1:0] sync_q;
    logic                prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], pin_i};
            prev_q <= sync_q[SYNC_LEN-1];
        end
    end

    assign rise_o =  sync_q[SYNC_LEN-1] & ~prev_q;
    assign fall_o = ~sync_q[SYNC_LEN-1] &  prev_q;
endmodule

// File: rtl/icap_meas.sv
module icap_meas
    import icap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] period_o,
    output logic [W-1:0] high_o
);
    meas_st_e     st_q, st_d;
    logic [W-1:0] start_q;
    logic [W-1:0] hlen_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = MS_IDLE;
        end else begin
            unique case (st_q)
                MS_IDLE: st_d = MS_ARM;
                MS_ARM:  if (rise_i) st_d = MS_HIGH;
                MS_HIGH: if (fall_i) st_d = MS_LOW;
                MS_LOW:  if (rise_i) st_d = MS_HIGH;
            endcase
        end
    end

    // results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= '0;
            hlen_q   <= '0;
            period_o <= '0;
            high_o   <= '0;
        end else if (en_i) begin
            unique case (st_q)
                MS_IDLE: begin
                    period_o <= '0;
                    high_o   <= '0;
                end
                MS_ARM: if (rise_i) start_q <= cnt_i;
                MS_HIGH: if (fall_i) hlen_q <= cnt_i - start_q;
                MS_LOW: if (rise_i) begin
                    period_o <= cnt_i - start_q;
                    high_o   <= hlen_q;
                    start_q  <= cnt_i;
                end
            endcase
        end
    end

    // R8: mode entry clears both results
    p_entry_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MS_IDLE && en_i) |=> (period_o == '0 && high_o == '0));

    // R6: period moves only at a completing rise
    p_period_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != MS_IDLE && !(st_q == MS_LOW && rise_i)) |=> $stable(period_o));

    // R7: high time moves only at a completing rise
    p_high_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != MS_IDLE && !(st_q == MS_LOW && rise_i)) |=> $stable(high_o));
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic         pin_i,
    input  logic [2:0]   mode_i,
    output logic [W-1:0] rise_cap_o,
    output logic [W-1:0] fall_cap_o,
    output logic [W-1:0] period_o,
    output logic [W-1:0] high_o,
    output logic         cap_evt_o,
    output logic         toggle_evt_o
);
    logic rise, fall;
    logic rise_sel, fall_sel, meas_en;

    icap_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        rise_sel = 1'b0;
        fall_sel = 1'b0;
        meas_en  = 1'b0;
        case (mode_i)
            CM_RISE:  rise_sel = 1'b1;
            CM_FALL:  fall_sel = 1'b1;
            CM_BOTH:  begin rise_sel = 1'b1; fall_sel = 1'b1; end
            CM_WIDTH: begin rise_sel = 1'b1; fall_sel = 1'b1; meas_en = 1'b1; end
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cap_o   <= '0;
            fall_cap_o   <= '0;
            cap_evt_o    <= 1'b0;
            toggle_evt_o <= 1'b0;
        end else begin
            if (rise && rise_sel) rise_cap_o <= cnt_i;
            if (fall && fall_sel) fall_cap_o <= cnt_i;
            cap_evt_o    <= (rise && rise_sel) || (fall && fall_sel);
            toggle_evt_o <= rise || fall;
        end
    end

    icap_meas #(.W(W)) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (meas_en),
        .rise_i   (rise),
        .fall_i   (fall),
        .cnt_i    (cnt_i),
        .period_o (period_o),
        .high_o   (high_o)
    );

    // R2: off mode holds both timestamps
    p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CM_OFF) |=> ($stable(rise_cap_o) && $stable(fall_cap_o)));

    // R3: rising-only mode never touches the fall register
    p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CM_RISE) |=> $stable(fall_cap_o));

    // R4: falling-only mode never touches the rise register
    p_fall_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CM_FALL) |=> $stable(rise_cap_o));

    // R9: a capture event needs a capturing mode one cycle earlier
    p_evt_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_o |-> ($past(mode_i) inside {3'd1, 3'd2, 3'd3, 3'd4}));

    // R10, R11: toggle event follows a pin change through the sync path
    p_toggle_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_evt_o |-> ($past(pin_i, 3) != $past(pin_i, 4)));
endmodule

// File: tb/icap_unit_tb.sv
module icap_unit_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_i = '0;
    logic         pin_i = 1'b0;
    logic [2:0]   mode_i = 3'd0;
    logic [W-1:0] rise_cap_o, fall_cap_o, period_o, high_o;
    logic         cap_evt_o, toggle_evt_o;

    int checks = 0;
    int fails  = 0;
    int cap_n  = 0;
    int tog_n  = 0;

    always #2 clk = ~clk;

    icap_unit #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .pin_i(pin_i), .mode_i(mode_i),
        .rise_cap_o(rise_cap_o), .fall_cap_o(fall_cap_o), .period_o(period_o),
        .high_o(high_o), .cap_evt_o(cap_evt_o), .toggle_evt_o(toggle_evt_o)
    );

    always @(negedge clk) begin
        if (cap_evt_o)    cap_n++;
        if (toggle_evt_o) tog_n++;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge_at(logic lvl, int cv);
        @(negedge clk);
        pin_i = lvl;
        cnt_i = W'(cv);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mode(int m);
        @(negedge clk);
        mode_i = 3'(m);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 rise", int'(rise_cap_o), 0);
        chk("R1 fall", int'(fall_cap_o), 0);
        chk("R1 period", int'(period_o), 0);
        chk("R1 high", int'(high_o), 0);
        chk("R1 events", int'({cap_evt_o, toggle_evt_o}), 0);
    endtask

    task automatic t_rise_only;
        int c0;
        set_mode(1);
        c0 = cap_n;
        edge_at(1'b1, 111);
        chk("R3 rise stamp", int'(rise_cap_o), 111);
        edge_at(1'b0, 222);
        chk("R3 fall ignored", int'(fall_cap_o), 0);
        chk("R9 one pulse", cap_n - c0, 1);
    endtask

    task automatic t_fall_only;
        set_mode(2);
        edge_at(1'b1, 333);
        chk("R4 rise ignored", int'(rise_cap_o), 111);
        edge_at(1'b0, 444);
        chk("R4 fall stamp", int'(fall_cap_o), 444);
    endtask

    task automatic t_both;
        set_mode(3);
        edge_at(1'b1, 555);
        edge_at(1'b0, 666);
        chk("R5 rise", int'(rise_cap_o), 555);
        chk("R5 fall", int'(fall_cap_o), 666);
    endtask

    task automatic t_off;
        int c0, t0;
        set_mode(0);
        c0 = cap_n;
        t0 = tog_n;
        edge_at(1'b1, 777);
        edge_at(1'b0, 888);
        chk("R2 rise held", int'(rise_cap_o), 555);
        chk("R2 fall held", int'(fall_cap_o), 666);
        chk("R2 no capture evt", cap_n - c0, 0);
        chk("R10 toggles in off mode", tog_n - t0, 2);
        set_mode(6);
        edge_at(1'b1, 999);
        edge_at(1'b0, 1000);
        chk("R2 code 6 rise held", int'(rise_cap_o), 555);
    endtask

    task automatic t_latency;
        set_mode(1);
        @(negedge clk);
        pin_i = 1'b1;
        cnt_i = W'(100);
        @(negedge clk);
        cnt_i = W'(200);
        @(negedge clk);
        cnt_i = W'(300);
        @(negedge clk);
        cnt_i = W'(400);
        repeat (3) @(negedge clk);
        chk("R11 sampled counter", int'(rise_cap_o), 300);
        edge_at(1'b0, 0);
    endtask

    task automatic t_meas;
        int c0;
        set_mode(4);
        chk("R8 period after entry", int'(period_o), 0);
        chk("R8 high after entry", int'(high_o), 0);
        edge_at(1'b1, 100);
        edge_at(1'b0, 130);
        chk("R8 period before cycle", int'(period_o), 0);
        chk("R8 high before cycle", int'(high_o), 0);
        c0 = cap_n;
        edge_at(1'b1, 200);
        chk("R6 period", int'(period_o), 100);
        chk("R7 high", int'(high_o), 30);
        chk("R7 rise stamp same cycle", int'(rise_cap_o), 200);
        chk("R9 one pulse at completing rise", cap_n - c0, 1);
        edge_at(1'b0, 260);
        chk("R7 high waits for rise", int'(high_o), 30);
        chk("R5 fall in width mode", int'(fall_cap_o), 260);
        edge_at(1'b1, 320);
        chk("R6 period 2", int'(period_o), 120);
        chk("R7 high 2", int'(high_o), 60);
        edge_at(1'b0, 330);
    endtask

    task automatic t_wrap;
        set_mode(0);
        set_mode(4);
        chk("R8 re-entry clear", int'(period_o), 0);
        edge_at(1'b1, 65530);
        edge_at(1'b0, 65534);
        edge_at(1'b1, 4);
        chk("R6 wrapped period", int'(period_o), 10);
        chk("R7 high", int'(high_o), 4);
        edge_at(1'b0, 9);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rise_only();
        t_fall_only();
        t_both();
        t_off();
        t_latency();
        t_meas();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule